// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block looks at every interrupt request line on each clock and names the one request the processor should service next. It returns a valid flag, a source index and the 16-bit vector address of that source. Six sources sit in a fixed, non-maskable order: power-on/pin reset, clock-monitor reset, watchdog reset, illegal-opcode trap, software interrupt and the high-priority external line. The last of these takes part only while its own mask bit is clear. A parameterised group of maskable sources follows. Index 0 of that group is the external IRQ line. The whole group is blocked by a global mask input. A software-written promotion register can lift any one maskable source to the top of its group.

The processor core reads the registered outputs when it decides to take an interrupt. The request inputs are levels, not events. There is no back-pressure at either edge: the result is worked out again on every clock and only describes the latest sample, so no ready signal is needed and none exists. A request that drops before the core acts on it is simply no longer selected.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset, sel_valid is 0, sel_index is 0 and sel_vector is 0xFFFE. The high-priority line's mask bit is 1 and the promotion register holds 0xF2.
- R2: Non-maskable sources win over all maskable ones. They rank in this order, index 0 highest: por(0), clkmon(1), wdog(2), trap(3), swi(4), xirq(5). Their vectors are 0xFFFE, 0xFFFC, 0xFFFA, 0xFFF8, 0xFFF6 and 0xFFF4.
- R3: req_xirq is eligible only while the internal X mask bit is 0. While that bit is 1, the request is ignored.
- R4: A write with x_wr=1 and x_wdata=0 clears the X mask bit. A write with x_wdata=1 has no effect, so once the bit is cleared it stays cleared until reset.
- R5: While i_mask is 1, no maskable source is selected. Non-maskable sources are still selected.
- R6: Maskable source k (bit k of req_mask) has index 6+k and vector 0xFFF2-2k. Bit 0 is the external IRQ at 0xFFF2. Among unpromoted maskable sources, the one with the higher vector (the lower k) wins.
- R7: The promoted maskable source, when it requests, wins over every other maskable source. It still loses to any eligible non-maskable source.
- R8: A write with hp_wr=1 takes effect only if hp_wdata equals 0xF2-2k for some k below N_MSK, and it then promotes source k. Any other byte is ignored and the previous promotion stays.
- R9: The outputs are registered. They reflect the requests, masks and configuration sampled at the previous rising edge. A mask or promotion write takes part from the edge after the one that stores it.
- R10: When no request is eligible, sel_valid is 0 and sel_index and sel_vector keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_por | input | 1 | Power-on or pin reset request |
| req_clkmon | input | 1 | Clock-monitor reset request |
| req_wdog | input | 1 | Watchdog reset request |
| req_trap | input | 1 | Illegal-opcode trap request |
| req_swi | input | 1 | Software interrupt request |
| req_xirq | input | 1 | High-priority external line, gated by the X mask bit |
| req_mask | input | N_MSK (8) | Maskable requests; bit 0 is the external IRQ |
| i_mask | input | 1 | Global mask for the maskable group |
| x_wr | input | 1 | Write strobe for the X mask bit |
| x_wdata | input | 1 | Value written to the X mask bit (only 0 takes effect) |
| hp_wr | input | 1 | Write strobe for the promotion register |
| hp_wdata | input | 8 | Vector low byte of the source to promote |
| sel_valid | output | 1 | An eligible request was selected |
| sel_index | output | IDX_W (4) | Index of the selected source |
| sel_vector | output | 16 | Vector address of the selected source |

## Verification
Walking single requests through each position of both groups confirms the index and vector map. Removing non-maskable requests one at a time from the top separates their fixed order from any error in the mask gating. Pairs of maskable requests, run with and without a promotion, show whether the promotion register changes only the order inside the maskable group. Unmatched promotion bytes, attempts to set the X bit again, and a long random mix of requests, masks and writes show which writes are dropped and that the selection holds when nothing is eligible.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned NM_COUNT = 6;

  typedef enum logic [2:0] {
    NM_POR    = 3'd0,
    NM_CLKMON = 3'd1,
    NM_WDOG   = 3'd2,
    NM_TRAP   = 3'd3,
    NM_SWI    = 3'd4,
    NM_XIRQ   = 3'd5
  } nm_src_e;

  localparam logic [15:0] VEC_TOP = 16'hFFFE;

  // Every source owns one 16-bit vector slot, counted down from the top.
  function automatic logic [15:0] vec_of(input logic [7:0] idx);
    vec_of = VEC_TOP - {7'b0, idx, 1'b0};
  endfunction

endpackage

// File: rtl/irq_xmask_reg.sv
module irq_xmask_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  output logic x_q
);

  // One-way bit: starts set, may only ever be cleared.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= 1'b1;
    else if (wr && !wdata) x_q <= 1'b0;
  end

  p_x_one_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !x_q |=> !x_q);

  p_x_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata) |=> !x_q);

endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_MSK = 8,
  localparam int unsigned MW = (N_MSK > 1) ? $clog2(N_MSK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [MW-1:0]    promo_idx,
  output logic [N_MSK-1:0] promo_oh
);

  logic [N_MSK-1:0] match;
  logic [MW-1:0]    hit_idx;

  // Compare the written byte with each maskable vector low byte.
  for (genvar g = 0; g < N_MSK; g++) begin : g_match
    localparam logic [15:0] SLOT_VEC = vec_of(8'(NM_COUNT + g));
    assign match[g]    = (wdata == SLOT_VEC[7:0]);
    assign promo_oh[g] = (promo_idx == MW'(g));
  end

  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < N_MSK; k++) begin
      if (match[k]) hit_idx = MW'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) promo_idx <= '0;
    else if (wr && (|match)) promo_idx <= hit_idx;
  end

  p_bad_write_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(|match)) |=> $stable(promo_idx));

  p_promo_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    promo_idx <= MW'(N_MSK - 1));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_MSK = 8,
  localparam int unsigned MW    = (N_MSK > 1) ? $clog2(N_MSK) : 1,
  localparam int unsigned IDX_W = $clog2(NM_COUNT + N_MSK)
) (
  input  logic [NM_COUNT-1:0] nm_req,
  input  logic [N_MSK-1:0]    m_req,
  input  logic                x_mask,
  input  logic                i_mask,
  input  logic [MW-1:0]       promo_idx,
  input  logic [N_MSK-1:0]    promo_oh,
  output logic [NM_COUNT-1:0] nm_elig,
  output logic [N_MSK-1:0]    m_elig,
  output logic                found,
  output logic [IDX_W-1:0]    idx,
  output logic [15:0]         vec
);

  logic promo_hit;

  always_comb begin
    nm_elig          = nm_req;
    nm_elig[NM_XIRQ] = nm_req[NM_XIRQ] & ~x_mask;
    m_elig           = i_mask ? '0 : m_req;
    promo_hit        = |(m_elig & promo_oh);

    found = 1'b0;
    idx   = '0;
    // Maskable group: lowest bit (highest vector) wins unless promoted.
    for (int k = N_MSK - 1; k >= 0; k--) begin
      if (m_elig[k]) begin
        found = 1'b1;
        idx   = IDX_W'(NM_COUNT + k);
      end
    end
    if (promo_hit) idx = IDX_W'(NM_COUNT) + IDX_W'(promo_idx);
    // Fixed group overrides everything.
    for (int k = NM_COUNT - 1; k >= 0; k--) begin
      if (nm_elig[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
    vec = vec_of(8'(idx));
  end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_MSK = 8,
  localparam int unsigned MW    = (N_MSK > 1) ? $clog2(N_MSK) : 1,
  localparam int unsigned IDX_W = $clog2(NM_COUNT + N_MSK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_por,
  input  logic             req_clkmon,
  input  logic             req_wdog,
  input  logic             req_trap,
  input  logic             req_swi,
  input  logic             req_xirq,
  input  logic [N_MSK-1:0] req_mask,
  input  logic             i_mask,
  input  logic             x_wr,
  input  logic             x_wdata,
  input  logic             hp_wr,
  input  logic [7:0]       hp_wdata,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_index,
  output logic [15:0]      sel_vector
);

  logic [NM_COUNT-1:0] nm_req_w;
  logic [NM_COUNT-1:0] nm_elig_w;
  logic [N_MSK-1:0]    m_elig_w;
  logic [N_MSK-1:0]    promo_oh_w;
  logic [MW-1:0]       promo_idx_w;
  logic                x_mask_q;
  logic                found_w;
  logic [IDX_W-1:0]    idx_w;
  logic [15:0]         vec_w;

  assign nm_req_w = {req_xirq, req_swi, req_trap, req_wdog, req_clkmon, req_por};

  irq_xmask_reg u_xmask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (x_wr),
    .wdata (x_wdata),
    .x_q   (x_mask_q)
  );

  irq_prio_reg #(.N_MSK(N_MSK)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (hp_wr),
    .wdata     (hp_wdata),
    .promo_idx (promo_idx_w),
    .promo_oh  (promo_oh_w)
  );

  irq_pick #(.N_MSK(N_MSK)) u_pick (
    .nm_req    (nm_req_w),
    .m_req     (req_mask),
    .x_mask    (x_mask_q),
    .i_mask    (i_mask),
    .promo_idx (promo_idx_w),
    .promo_oh  (promo_oh_w),
    .nm_elig   (nm_elig_w),
    .m_elig    (m_elig_w),
    .found     (found_w),
    .idx       (idx_w),
    .vec       (vec_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_index  <= '0;
      sel_vector <= VEC_TOP;
    end else begin
      sel_valid <= found_w;
      if (found_w) begin
        sel_index  <= idx_w;
        sel_vector <= vec_w;
      end
    end
  end

  function automatic logic [NM_COUNT-1:0] above_mask(input logic [IDX_W-1:0] v);
    above_mask = '0;
    for (int k = 0; k < NM_COUNT; k++) begin
      if (k < int'(v)) above_mask[k] = 1'b1;
    end
  endfunction

  p_nm_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_index < IDX_W'(NM_COUNT))
      |-> (($past(nm_elig_w) & above_mask(sel_index)) == '0));

  p_xirq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_index == IDX_W'(NM_XIRQ)) |-> !$past(x_mask_q));

  p_imask_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_index >= IDX_W'(NM_COUNT))
      |-> (!$past(i_mask) && $past(nm_elig_w) == '0));

  p_promo_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_index >= IDX_W'(NM_COUNT) && $past(|(m_elig_w & promo_oh_w)))
      |-> (sel_index == IDX_W'(NM_COUNT) + IDX_W'($past(promo_idx_w))));

  p_valid_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $past(|{nm_req_w, req_mask}));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> ($stable(sel_vector) && $stable(sel_index)));

endmodule

// File: tb/sim_irq_vector_arbiter.sv
module sim_irq_vector_arbiter;

  localparam int N_MSK = 8;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_por = 0, req_clkmon = 0, req_wdog = 0, req_trap = 0, req_swi = 0, req_xirq = 0;
  logic [N_MSK-1:0] req_mask = '0;
  logic i_mask = 1'b0;
  logic x_wr = 1'b0, x_wdata = 1'b0;
  logic hp_wr = 1'b0;
  logic [7:0] hp_wdata = 8'h00;
  logic sel_valid;
  logic [IDX_W-1:0] sel_index;
  logic [15:0] sel_vector;

  always #10 clk = ~clk;

  irq_vector_arbiter #(.N_MSK(N_MSK)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_por(req_por), .req_clkmon(req_clkmon), .req_wdog(req_wdog),
    .req_trap(req_trap), .req_swi(req_swi), .req_xirq(req_xirq),
    .req_mask(req_mask), .i_mask(i_mask),
    .x_wr(x_wr), .x_wdata(x_wdata), .hp_wr(hp_wr), .hp_wdata(hp_wdata),
    .sel_valid(sel_valid), .sel_index(sel_index), .sel_vector(sel_vector)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 0;

  // Behavioural reference model.
  bit m_valid;
  int m_index;
  int m_vector;
  bit m_x;
  int m_promo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_index = 0; m_vector = 'hFFFE; m_x = 1; m_promo = 0;
    end else begin
      int pick;
      bit nm [6];
      pick = -1;
      nm[0] = req_por; nm[1] = req_clkmon; nm[2] = req_wdog;
      nm[3] = req_trap; nm[4] = req_swi; nm[5] = req_xirq && !m_x;
      for (int k = 0; k < 6; k++) if (pick < 0 && nm[k]) pick = k;
      if (pick < 0 && !i_mask) begin
        if (req_mask[m_promo]) pick = 6 + m_promo;
        else for (int k = 0; k < N_MSK; k++) if (pick < 0 && req_mask[k]) pick = 6 + k;
      end
      m_valid = (pick >= 0);
      if (pick >= 0) begin m_index = pick; m_vector = 'hFFFE - 2 * pick; end
      if (x_wr && !x_wdata) m_x = 0;
      if (hp_wr) for (int k = 0; k < N_MSK; k++) if (int'(hp_wdata) == 'hF2 - 2 * k) m_promo = k;
    end
  end

  task automatic check3(input string req, input bit v, input int i, input int vec);
    checks++;
    if (sel_valid !== v || (v && (int'(sel_index) != i || int'(sel_vector) != vec))
        || (!v && int'(sel_vector) != vec)) begin
      fails++;
      $display("FAIL %s: got valid=%0b idx=%0d vec=%h, expected valid=%0b idx=%0d vec=%h",
               req, sel_valid, sel_index, sel_vector, v, i, vec[15:0]);
    end
  endtask

  // Compare against the model away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check3(tag, m_valid, m_index, m_vector);
      if (!m_valid && int'(sel_index) != m_index) begin
        fails++;
        $display("FAIL %s: held idx=%0d expected %0d", tag, sel_index, m_index);
      end
    end
  end

  task automatic clr_req();
    {req_por, req_clkmon, req_wdog, req_trap, req_swi, req_xirq} = '0;
    req_mask = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hp_write(input logic [7:0] b);
    hp_wr = 1; hp_wdata = b; step(1); hp_wr = 0;
  endtask

  task automatic x_write(input logic b);
    x_wr = 1; x_wdata = b; step(1); x_wr = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    #1;
    // R1: reset state, no requests.
    tag = "R1";
    checks++;
    if (sel_valid !== 1'b0 || sel_vector !== 16'hFFFE || sel_index !== '0) begin
      fails++;
      $display("FAIL R1: got valid=%0b idx=%0d vec=%h, expected 0 0 fffe", sel_valid, sel_index, sel_vector);
    end
    step(2);

    // R2: fixed order, peel from the top (xirq gated by X=1 here).
    tag = "R2";
    {req_por, req_clkmon, req_wdog, req_trap, req_swi} = '1; req_mask = '1;
    step(2); req_por = 0; step(2); req_clkmon = 0; step(2);
    req_wdog = 0; step(2); req_trap = 0; step(2); req_swi = 0; i_mask = 1; step(2);
    clr_req(); i_mask = 0; step(2);

    // R3: xirq ignored while X is 1, then taken once cleared.
    tag = "R3";
    req_xirq = 1; step(3);
    x_write(1'b0); step(3);
    req_swi = 1; step(2); req_swi = 0; step(2);

    // R4: setting X back to 1 has no effect.
    tag = "R4";
    x_write(1'b1); step(3);
    req_mask = 8'h01; step(2);
    clr_req(); step(2);

    // R5: i_mask blocks the maskable group only.
    tag = "R5";
    i_mask = 1; req_mask = '1; step(3);
    req_trap = 1; step(2); req_trap = 0; step(2);
    i_mask = 0; step(2); clr_req(); step(2);

    // R6: walking single requests and pairs.
    tag = "R6";
    for (int k = 0; k < N_MSK; k++) begin req_mask = 8'(1 << k); step(2); end
    req_mask = 8'h90; step(2); req_mask = 8'h06; step(2); req_mask = 8'hFE; step(2);
    clr_req(); step(2);

    // R7: promote source 4 (0xEA).
    tag = "R7";
    hp_write(8'hEA);
    req_mask = 8'h11; step(2); req_mask = 8'h13; step(2);
    req_wdog = 1; step(2); req_wdog = 0; req_mask = 8'h01; step(2);
    clr_req(); step(2);

    // R8: unmatched bytes leave the promotion in place.
    tag = "R8";
    hp_write(8'hEB); hp_write(8'hF4); hp_write(8'hE2); hp_write(8'h00);
    req_mask = 8'h11; step(3);
    hp_write(8'hE4); req_mask = 8'h81; step(3);
    clr_req(); step(2);
    rst_n = 0; step(2); rst_n = 1; step(1);
    req_mask = 8'h81; step(3); clr_req(); step(2);

    // R9: one-cycle latency around single request edges.
    tag = "R9";
    req_swi = 1; step(1); req_swi = 0; step(1); req_mask = 8'h20; step(1); clr_req(); step(2);

    // R10: idle after activity holds index and vector.
    tag = "R10";
    req_mask = 8'h08; step(2); clr_req(); step(4);

    // Random mix checked against the model.
    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      {req_por, req_clkmon, req_wdog} = (r < 10) ? 3'($urandom) : 3'b000;
      {req_trap, req_swi, req_xirq} = (r < 40) ? 3'($urandom) : 3'b000;
      req_mask = 8'($urandom);
      i_mask = ($urandom_range(0, 3) == 0);
      hp_wr = ($urandom_range(0, 7) == 0);
      hp_wdata = ($urandom_range(0, 1) == 0) ? 8'(8'hF2 - 2 * $urandom_range(0, N_MSK - 1)) : 8'($urandom);
      x_wr = ($urandom_range(0, 30) == 0);
      x_wdata = 1'($urandom);
      if (n % 500 == 499) begin rst_n = 0; step(1); rst_n = 1; end
      step(1);
    end
    clr_req(); hp_wr = 0; x_wr = 0; step(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule